// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers transfer-done events from a set of DMA channel engines and folds them into a single interrupt line. Each channel has a kick input that marks a transfer outstanding and a done input from its engine. A completed transfer leaves a sticky status bit that software clears by writing 1. A per-channel enable mask decides which status bits reach the interrupt. Status bits are captured whatever the mask holds.

A global clear control in the configuration word cancels every outstanding transfer. For one cycle it strobes an abort to each channel that was pending. On the next edge it marks those channels complete, exactly as if they had finished normally, and then clears itself. Software uses a small word-addressed register port with a combinational read path to access the status word, the enable word and the configuration word.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, status, enable and pending state are all zero, the clear control reads 0, irq_o is low and abort_o is all zero.
- R2: The status word (address 0) and the enable word (address 1) place channel n at bit 2n. All odd bits, and all bits from 2*NUM_CH up, read as zero. Address 3 reads as zero.
- R3: A done pulse on channel n sets status bit 2n at the next clock edge. Writing a 1 to bit 2n of address 0 clears it at the next edge. Writing 0 to a status bit leaves it unchanged.
- R4: A done event on a channel whose status bit is already set is absorbed. The bit stays set and no second indication is produced.
- R5: When a write-1 clear and a done event hit the same channel in the same cycle, the bit stays set.
- R6: Status capture does not depend on the enable word. A disabled channel still shows its status bit.
- R7: irq_o is high exactly when some channel has both its status bit and its enable bit set. It follows register state within the same cycle.
- R8: Writing 1 to bit 8 of address 2 sets the clear control. For the one following cycle, bit 8 reads 1 and abort_o shows exactly the channels that are pending. At the next edge those channels get their status set and lose their pending flag, and the control returns to 0.
- R9: A kick marks its channel pending. A done event removes the pending flag, so a later clear does not abort that channel. A kick in the same cycle as a done or abort leaves the channel pending.
- R10: A write to address 2 with bit 8 at 0, a write of 1 to bit 8 while the control is already set, and any write to address 3 have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address: 0 status, 1 enable, 2 config, 3 reserved |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| kick_i | input | 10 | Per-channel transfer start |
| done_i | input | 10 | Per-channel completion from the engines |
| abort_o | output | 10 | Per-channel one-cycle abort strobe |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench first drives done events on isolated channels with the mask both clear and set. This separates status capture (R6) from interrupt gating (R7). It then overlaps done events with write-1 clears, both on the same channel in the same cycle and on different channels. It also repeats a done on an already-set channel, which tells absorption and write priority apart from a plain clear. Clear-control runs are made with mixed pending sets: some channels kicked and finished, some only kicked, and one kicked in the abort cycle itself. These show which channels are aborted and whether a fresh kick survives. Writes with no effect go to the configuration word and the reserved address, and their result is read back through the status and config words.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned CLR_BIT = 8;
  localparam int unsigned CH_STRIDE = 2;

  typedef enum logic [REG_AW-1:0] {
    ADDR_STAT = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_CFG  = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_CH-1:0]   w1c_o,
  output logic                en_wr_o,
  output logic [NUM_CH-1:0]   en_data_o,
  output logic                clr_o
);
  logic wr_stat, wr_cfg;
  logic clr_q;

  assign wr_stat = wr_en_i && (addr_i == ADDR_STAT);
  assign wr_cfg  = wr_en_i && (addr_i == ADDR_CFG);
  assign en_wr_o = wr_en_i && (addr_i == ADDR_EN);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_slice
    assign w1c_o[n]     = wr_stat & wdata_i[CH_STRIDE*n];
    assign en_data_o[n] = wdata_i[CH_STRIDE*n];
  end

  // self-clearing; a second set while active is ignored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    clr_q <= 1'b0;
    else if (clr_q) clr_q <= 1'b0;
    else            clr_q <= wr_cfg & wdata_i[CLR_BIT];
  end

  assign clr_o = clr_q;
endmodule

// File: rtl/dma_irq_chan.sv
module dma_irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  input  logic done_i,
  input  logic w1c_i,
  input  logic clr_i,
  input  logic en_wr_i,
  input  logic en_data_i,
  output logic stat_o,
  output logic en_o,
  output logic pend_o,
  output logic abort_o,
  output logic req_o
);
  logic stat_q, en_q, pend_q;
  logic abort;

  assign abort = clr_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      // completion (real or by abort) beats a same-cycle clear
      stat_q <= (stat_q & ~w1c_i) | done_i | abort;
      pend_q <= kick_i | (pend_q & ~done_i & ~abort);
      if (en_wr_i) en_q <= en_data_i;
    end
  end

  assign stat_o  = stat_q;
  assign en_o    = en_q;
  assign pend_o  = pend_q;
  assign abort_o = abort;
  assign req_o   = stat_q & en_q;
endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic [REG_AW-1:0] addr_i,
  input  logic [NUM_CH-1:0] stat_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] stat_w, en_w, cfg_w;

  always_comb begin
    stat_w = '0;
    en_w   = '0;
    cfg_w  = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      stat_w[CH_STRIDE*n] = stat_i[n];
      en_w[CH_STRIDE*n]   = en_i[n];
    end
    cfg_w[CLR_BIT] = clr_i;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_STAT: rdata_o = stat_w;
      ADDR_EN:   rdata_o = en_w;
      ADDR_CFG:  rdata_o = cfg_w;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_CH-1:0]   kick_i,
  input  logic [NUM_CH-1:0]   done_i,
  output logic [NUM_CH-1:0]   abort_o,
  output logic                irq_o
);
  logic [NUM_CH-1:0] w1c, en_data, stat_vec, en_vec, pend_vec, req_vec;
  logic              en_wr, clr;

  dma_irq_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .w1c_o(w1c), .en_wr_o(en_wr), .en_data_o(en_data), .clr_o(clr)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    dma_irq_chan u_chan (
      .clk_i, .rst_ni,
      .kick_i(kick_i[n]), .done_i(done_i[n]), .w1c_i(w1c[n]),
      .clr_i(clr), .en_wr_i(en_wr), .en_data_i(en_data[n]),
      .stat_o(stat_vec[n]), .en_o(en_vec[n]), .pend_o(pend_vec[n]),
      .abort_o(abort_o[n]), .req_o(req_vec[n])
    );
  end

  assign irq_o = |req_vec;

  dma_irq_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
    .addr_i, .stat_i(stat_vec), .en_i(en_vec), .clr_i(clr), .rdata_o
  );
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [REG_AW-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_CH-1:0]   done_i,
  input logic [NUM_CH-1:0]   abort_o,
  input logic                irq_o,
  input logic [NUM_CH-1:0]   stat_vec,
  input logic [NUM_CH-1:0]   en_vec
);
  logic [NUM_CH-1:0] w1c_m;
  logic [DATA_W-1:0] odd_m;

  always_comb begin
    w1c_m = '0;
    odd_m = '0;
    for (int n = 0; n < NUM_CH; n++)
      w1c_m[n] = wr_en_i && (addr_i == ADDR_STAT) && wdata_i[CH_STRIDE*n];
    for (int b = 0; b < DATA_W; b++)
      if ((b % 2) == 1) odd_m[b] = 1'b1;
  end

  p_odd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_CFG) |-> ((rdata_o & odd_m) == '0));

  p_done_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_i) |=> ((stat_vec & $past(done_i)) == $past(done_i)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stat_vec) |=> (($past(stat_vec) & ~stat_vec & ~$past(w1c_m)) == '0));

  p_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(stat_vec & en_vec)));

  p_abort_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|abort_o) |=> ((stat_vec & $past(abort_o)) == $past(abort_o)));

  p_abort_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|abort_o) |=> (abort_o == '0));
endmodule

bind dma_irq_agg dma_irq_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .done_i(done_i), .abort_o(abort_o),
  .irq_o(irq_o), .stat_vec(stat_vec), .en_vec(en_vec)
);

// File: tb/dma_irq_agg_test.sv
module dma_irq_agg_test;
  localparam int NCH = 10;
  localparam int DW = 32;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NCH-1:0] kick = '0, done = '0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] abort;
  logic irq;

  int vec_cnt = 0, err_cnt = 0;
  bit finished = 0;
  string tag = "R1";

  bit m_stat[NCH], m_en[NCH], m_pend[NCH];
  bit m_clr = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_irq_agg #(.NUM_CH(NCH), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .kick_i(kick), .done_i(done),
    .abort_o(abort), .irq_o(irq)
  );

  function automatic logic [DW-1:0] exp_rdata();
    logic [DW-1:0] r = '0;
    for (int n = 0; n < NCH; n++) begin
      if (addr == 2'd0) r[2*n] = m_stat[n];
      if (addr == 2'd1) r[2*n] = m_en[n];
    end
    if (addr == 2'd2) r[8] = m_clr;
    return r;
  endfunction

  function automatic bit exp_irq();
    bit a = 0;
    for (int n = 0; n < NCH; n++) a |= m_stat[n] & m_en[n];
    return a;
  endfunction

  function automatic logic [NCH-1:0] exp_abort();
    logic [NCH-1:0] a = '0;
    for (int n = 0; n < NCH; n++) a[n] = m_clr & m_pend[n];
    return a;
  endfunction

  task automatic compare();
    logic [DW-1:0] er = exp_rdata();
    logic [NCH-1:0] ea = exp_abort();
    bit ei = exp_irq();
    vec_cnt++;
    if (rdata !== er || abort !== ea || irq !== ei) begin
      err_cnt++;
      $display("FAIL %s: rdata=%h abort=%b irq=%b expected rdata=%h abort=%b irq=%b",
               tag, rdata, abort, irq, er, ea, ei);
    end
  endtask

  task automatic model_edge();
    bit n_stat[NCH], n_pend[NCH];
    bit n_clr;
    for (int n = 0; n < NCH; n++) begin
      bit w1c = wr_en && addr == 2'd0 && wdata[2*n];
      bit ab = m_clr && m_pend[n];
      n_stat[n] = (m_stat[n] && !w1c) || done[n] || ab;
      n_pend[n] = kick[n] || (m_pend[n] && !done[n] && !ab);
      if (wr_en && addr == 2'd1) m_en[n] = wdata[2*n];
    end
    n_clr = m_clr ? 1'b0 : (wr_en && addr == 2'd2 && wdata[8]);
    m_stat = n_stat;
    m_pend = n_pend;
    m_clr = n_clr;
  endtask

  // drive at negedge, compare, then advance model at posedge
  task automatic step(input bit we, input logic [1:0] a, input logic [DW-1:0] d,
                      input logic [NCH-1:0] k, input logic [NCH-1:0] dn);
    wr_en = we; addr = a; wdata = d; kick = k; done = dn;
    #1;
    compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle(input logic [1:0] a);
    step(0, a, '0, '0, '0);
  endtask

  function automatic logic [DW-1:0] chbit(input int n);
    return DW'(1) << (2*n);
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      err_cnt++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < NCH; n++) begin m_stat[n] = 0; m_en[n] = 0; m_pend[n] = 0; end
    repeat (3) @(negedge clk);
    tag = "R1";
    for (int a = 0; a < 4; a++) begin addr = 2'(a); #1; compare(); end
    rst_ni = 1'b1;
    @(negedge clk);
    idle(0); idle(1); idle(2);

    tag = "R3";
    step(0, 0, '0, '0, 10'b00_0000_0101);
    idle(0);
    step(1, 0, '0, '0, '0);
    step(1, 0, chbit(0), '0, '0);
    idle(0);

    tag = "R6";
    step(0, 0, '0, '0, 10'b10_0000_0000);
    idle(0); idle(1);

    tag = "R7";
    step(1, 1, chbit(9) | chbit(4), '0, '0);
    idle(0); idle(1);
    step(1, 0, chbit(9), '0, '0);
    idle(0);
    step(0, 0, '0, '0, 10'b00_0001_0000);
    idle(0);
    step(1, 0, chbit(2) | chbit(4), '0, '0);
    idle(0);

    tag = "R4";
    step(0, 0, '0, '0, 10'b00_0001_0000);
    step(0, 0, '0, '0, 10'b00_0001_0000);
    step(0, 0, '0, '0, 10'b00_0001_0000);
    idle(0);

    tag = "R5";
    step(1, 0, chbit(4) | chbit(1), '0, 10'b00_0001_0010);
    idle(0);
    step(1, 0, '1, '0, '0);
    idle(0);

    tag = "R2";
    step(0, 0, '0, '0, '1);
    idle(0);
    step(1, 1, '1, '0, '0);
    idle(1); idle(3);
    step(1, 0, '1, '0, '0);
    step(1, 1, '0, '0, '0);
    idle(0);

    tag = "R9";
    step(0, 0, '0, 10'b00_0000_1111, '0);
    step(0, 0, '0, '0, 10'b00_0000_0011);
    step(1, 0, '1, '0, '0);
    idle(0);

    tag = "R8";
    step(1, 2, DW'(1) << 8, '0, '0);
    step(0, 2, '0, 10'b00_0000_0100, '0);
    idle(2); idle(0);
    step(1, 1, '1, '0, '0);
    step(1, 2, DW'(1) << 8, '0, '0);
    idle(0); idle(0); idle(2);
    step(1, 0, '1, '0, '0);

    tag = "R10";
    step(0, 0, '0, 10'b11_0000_0000, '0);
    step(1, 2, ~(DW'(1) << 8), '0, '0);
    idle(2);
    step(1, 3, '1, '0, '0);
    idle(0); idle(3);
    step(1, 2, DW'(1) << 8, '0, '0);
    step(1, 2, DW'(1) << 8, '0, '0);
    idle(2); idle(0);

    tag = "R9";
    step(0, 0, '0, 10'b00_1000_0000, '0);
    step(1, 2, DW'(1) << 8, '0, '0);
    step(0, 2, '0, 10'b00_1000_0000, 10'b00_1000_0000);
    idle(2); idle(0);

    for (int i = 0; i < 40; i++) begin
      tag = "R3";
      step((i % 3) == 0, 2'(i % 4), DW'(32'h5a5 * (i + 1)), NCH'(i * 7), NCH'(i * 13));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule